// File: doc/BRIEF.md
# Tree-Structured Carry-Lookahead Adder

A purely combinational adder for two operands of equal width plus a carry-in. It returns the sum word and a carry-out. The same logic serves unsigned and two's-complement operands, because the low WIDTH bits of the result are identical in both readings. Every bit position has a leaf cell. The leaf forms its sum bit from the two operand bits and a carry that it receives from the tree. It also reports whether the position creates a carry (both bits set) and whether it passes one on (either bit set). The leaf never computes a carry-out of its own.

Above the leaves sits a balanced tree of lookahead nodes, with RADIX children per node (four by default). On the way up, each node folds the create/pass pairs of its children into one pair for its whole span. On the way down, it hands its incoming carry to the lowest child unchanged. Each higher child gets a carry that the node works out in parallel from the pairs of the children below it. The root pair and the external carry-in give the carry-out. Carry delay therefore grows with the number of tree levels, which is log base RADIX of WIDTH, and not with WIDTH itself.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals (`a` + `b` + `cin`) modulo 2^WIDTH for every operand pair, whether the operands are read as unsigned or as two's complement.
- R2: `cout` equals bit WIDTH of the full-precision total `a` + `b` + `cin`.
- R3: When every position passes a carry and none creates one (`a` is the bitwise inverse of `b`), `sum` is all ones if `cin`=0 and all zeros if `cin`=1, and `cout` equals `cin`.
- R4: With both operands zero, `sum` equals `cin` in bit 0 and zero elsewhere, and `cout` is 0.
- R5: All-ones plus one (`a`=all ones, `b`=1, `cin`=0, or `a`=all ones, `b`=0, `cin`=1) gives `sum`=0 and `cout`=1.
- R6: Two all-ones operands give `sum` = all ones except bit 0, which equals `cin`, and `cout`=1.
- R7: Alternating patterns (0101… plus 1010…, and each pattern added to itself) give the arithmetic result on both `sum` and `cout`.
- R8: A carry rippling out of the low k bits (`a`=2^k−1, `b`=1, `cin`=0) lands at bit k for every k from 1 to WIDTH−1, so carries cross every group and level boundary of the tree correctly.
- R9: WIDTH must be a power of RADIX and RADIX at least 2, which is checked at elaboration. The defaults are WIDTH=16 and RADIX=4, and WIDTH=64 with RADIX=4 also builds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
A 4-bit adder built with radix 2 has two node levels. It is swept over every operand pair with both carry-in values, so every path through a two-level tree is exercised. The 16-bit default and a 64-bit build are then driven with random operands. They also receive the full-propagate pattern, which tells a true lookahead path from one that wrongly uses a position's own generate. They also receive all-ones plus one and zero operands with a carry-in, which separate the carry-in delivery from the root carry-out term. Alternating patterns place creates and passes in every other position. A walking ripple (2^k−1 plus 1) puts the carry boundary at each bit in turn, so a wrong child-carry at any node of any level shows up.

// File: rtl/cla_pkg.sv
package cla_pkg;

   // carry-create / carry-pass pair for a span of bit positions
   typedef struct packed {
      logic g;
      logic p;
   } gp_t;

   // fold a more-significant span (hi) onto a less-significant span (lo)
   function automatic gp_t gp_combine(gp_t hi, gp_t lo);
      gp_t r;
      r.p = hi.p & lo.p;
      r.g = hi.g | (lo.g & hi.p);
      return r;
   endfunction

   // true when w is radix raised to a non-negative integer power
   function automatic bit cla_is_power(int w, int radix);
      int v;
      v = w;
      if (radix < 2 || w < 1) return 1'b0;
      while (v > 1) begin
         if (v % radix != 0) return 1'b0;
         v = v / radix;
      end
      return 1'b1;
   endfunction

   // number of node levels above the leaves
   function automatic int cla_levels(int w, int radix);
      int v;
      int n;
      v = w;
      n = 0;
      while (v > 1) begin
         v = v / radix;
         n = n + 1;
      end
      return n;
   endfunction

endpackage

// File: rtl/cla_leaf.sv
module cla_leaf (
   input  logic a_bit,
   input  logic b_bit,
   input  logic c_in,
   output logic s_bit,
   output logic gen,
   output logic prop
);

   assign s_bit = (a_bit ^ b_bit) ^ c_in;
   assign gen   = a_bit & b_bit;
   assign prop  = a_bit | b_bit;

endmodule

// File: rtl/cla_node.sv
module cla_node
   import cla_pkg::*;
#(
   parameter int RADIX = 4
) (
   input  gp_t [RADIX-1:0]  kid,
   input  logic             c_in,
   output gp_t              grp,
   output logic [RADIX-1:0] kid_cin
);

   // carries to the children: child 0 takes the node carry unchanged,
   // every higher child gets its own prefix of the lower children
   always_comb begin
      kid_cin[0] = c_in;
      for (int k = 1; k < RADIX; k++) begin
         gp_t acc;
         acc = kid[0];
         for (int j = 1; j < k; j++) begin
            acc = gp_combine(kid[j], acc);
         end
         kid_cin[k] = acc.g | (acc.p & c_in);
      end
   end

   // group pair over all children, low to high
   always_comb begin
      gp_t all;
      all = kid[0];
      for (int k = 1; k < RADIX; k++) begin
         all = gp_combine(kid[k], all);
      end
      grp = all;
   end

   // checks beside the carry distribution
   always_comb begin
      logic any_gen;
      any_gen = 1'b0;
      for (int k = 0; k < RADIX; k++) any_gen = any_gen | kid[k].g;
      AST_ALL_PASS_CARRY: assert (!(grp.p && c_in) || (kid_cin == {RADIX{1'b1}}))
         else $error("full-pass group did not deliver carry to every child"); // R3
      AST_NO_SOURCE_NO_CARRY: assert (c_in || any_gen || (kid_cin == '0))
         else $error("child carry appeared with no carry source"); // R8
   end

endmodule

// File: rtl/cla_tree.sv
module cla_tree
   import cla_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int RADIX = 4
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             c_in,
   output logic [WIDTH-1:0] sum,
   output gp_t              grp
);

   generate
      if (WIDTH == 1) begin : g_leaf
         logic gen_w;
         logic prop_w;
         cla_leaf u_leaf (
            .a_bit (a[0]),
            .b_bit (b[0]),
            .c_in  (c_in),
            .s_bit (sum[0]),
            .gen   (gen_w),
            .prop  (prop_w)
         );
         assign grp = '{g: gen_w, p: prop_w};
      end else begin : g_branch
         localparam int SUBW = WIDTH / RADIX;
         gp_t [RADIX-1:0]  kid_gp;
         logic [RADIX-1:0] kid_c;

         for (genvar k = 0; k < RADIX; k++) begin : g_kid
            cla_tree #(
               .WIDTH (SUBW),
               .RADIX (RADIX)
            ) u_sub (
               .a    (a[k*SUBW +: SUBW]),
               .b    (b[k*SUBW +: SUBW]),
               .c_in (kid_c[k]),
               .sum  (sum[k*SUBW +: SUBW]),
               .grp  (kid_gp[k])
            );
         end

         cla_node #(
            .RADIX (RADIX)
         ) u_node (
            .kid     (kid_gp),
            .c_in    (c_in),
            .grp     (grp),
            .kid_cin (kid_c)
         );
      end
   endgenerate

endmodule

// File: rtl/cla_adder.sv
module cla_adder
   import cla_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int RADIX = 4
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);

   localparam int LEVELS = cla_levels(WIDTH, RADIX);

   initial begin
      AST_SHAPE_LEGAL: assert (cla_is_power(WIDTH, RADIX) && LEVELS >= 1)
         else $error("WIDTH must be a power of RADIX, RADIX at least 2"); // R9
   end

   gp_t root;

   cla_tree #(
      .WIDTH (WIDTH),
      .RADIX (RADIX)
   ) u_tree (
      .a    (a),
      .b    (b),
      .c_in (cin),
      .sum  (sum),
      .grp  (root)
   );

   assign cout = root.g | (root.p & cin);

   // port-level checks against plain arithmetic
   always_comb begin
      logic [WIDTH:0] total;
      total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
      AST_SUM_EXACT: assert (sum == total[WIDTH-1:0])
         else $error("sum differs from arithmetic total"); // R1
      AST_COUT_EXACT: assert (cout == total[WIDTH])
         else $error("carry-out differs from arithmetic total"); // R2
      AST_FULL_PASS: assert (((a ^ b) != {WIDTH{1'b1}}) ||
                             ((sum == {WIDTH{~cin}}) && (cout == cin)))
         else $error("full-pass operands mishandled"); // R3
   end

endmodule

// File: tb/cla_adder_tb_top.sv
module cla_adder_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int fails  = 0;

   // default 16-bit, radix 4
   logic [15:0] a16, b16, s16;
   logic        c16, co16;
   cla_adder #(.WIDTH(16), .RADIX(4)) dut_i (
      .a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16));

   // small 4-bit, radix 2 (two node levels) for exhaustive sweep
   logic [3:0] a4, b4, s4;
   logic       c4, co4;
   cla_adder #(.WIDTH(4), .RADIX(2)) dut_small_i (
      .a(a4), .b(b4), .cin(c4), .sum(s4), .cout(co4));

   // wide 64-bit, radix 4
   logic [63:0] a64, b64, s64;
   logic        c64, co64;
   cla_adder #(.WIDTH(64), .RADIX(4)) dut_wide_i (
      .a(a64), .b(b64), .cin(c64), .sum(s64), .cout(co64));

   task automatic report(input bit ok, input string req,
                         input logic [64:0] act, input logic [64:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run16(input logic [15:0] x, input logic [15:0] y,
                        input logic ci, input string req);
      logic [16:0] exp;
      @(negedge clk);
      a16 = x; b16 = y; c16 = ci;
      exp = {1'b0, x} + {1'b0, y} + {16'd0, ci};
      #2;
      report({co16, s16} == exp, req, {48'd0, co16, s16}, {48'd0, exp});
   endtask

   task automatic run64(input logic [63:0] x, input logic [63:0] y,
                        input logic ci, input string req);
      logic [64:0] exp;
      @(negedge clk);
      a64 = x; b64 = y; c64 = ci;
      exp = {1'b0, x} + {1'b0, y} + {64'd0, ci};
      #2;
      report({co64, s64} == exp, req, {co64, s64}, exp);
   endtask

   initial begin
      a16 = '0; b16 = '0; c16 = 1'b0;
      a4  = '0; b4  = '0; c4  = 1'b0;
      a64 = '0; b64 = '0; c64 = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // idle state: zero operands, no carry -> zero result (R4)
      @(negedge clk); #2;
      report({co16, s16} == 17'd0, "R4 idle zero", {48'd0, co16, s16}, 65'd0);

      // exhaustive small sweep (R1, R2)
      for (int ci = 0; ci < 2; ci++) begin
         for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
               logic [4:0] exp;
               @(negedge clk);
               a4 = x[3:0]; b4 = y[3:0]; c4 = ci[0];
               exp = {1'b0, a4} + {1'b0, b4} + {4'd0, c4};
               #2;
               report(s4 == exp[3:0], "R1 small sum", {61'd0, s4}, {61'd0, exp[3:0]});
               report(co4 == exp[4], "R2 small cout", {64'd0, co4}, {64'd0, exp[4]});
            end
         end
      end

      // zeros with carry-in (R4)
      run16(16'h0000, 16'h0000, 1'b1, "R4 zero+cin");
      run64(64'd0, 64'd0, 1'b1, "R4 zero+cin wide");

      // all ones plus one (R5)
      run16(16'hFFFF, 16'h0001, 1'b0, "R5 ones+1");
      run16(16'hFFFF, 16'h0000, 1'b1, "R5 ones+cin");
      run64({64{1'b1}}, 64'd1, 1'b0, "R5 ones+1 wide");

      // full propagate (R3)
      run16(16'hA5C3, 16'h5A3C, 1'b0, "R3 full pass c0");
      run16(16'hA5C3, 16'h5A3C, 1'b1, "R3 full pass c1");
      run64(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b1, "R3 full pass wide");

      // all-ones pair (R6)
      run16(16'hFFFF, 16'hFFFF, 1'b0, "R6 ones+ones c0");
      run16(16'hFFFF, 16'hFFFF, 1'b1, "R6 ones+ones c1");
      run64({64{1'b1}}, {64{1'b1}}, 1'b1, "R6 ones+ones wide");

      // alternating (R7)
      run16(16'h5555, 16'hAAAA, 1'b0, "R7 alt 5+A");
      run16(16'h5555, 16'hAAAA, 1'b1, "R7 alt 5+A cin");
      run16(16'h5555, 16'h5555, 1'b0, "R7 alt 5+5");
      run16(16'hAAAA, 16'hAAAA, 1'b1, "R7 alt A+A");
      run64({16{4'h5}}, {16{4'hA}}, 1'b1, "R7 alt wide");
      run64({16{4'hA}}, {16{4'hA}}, 1'b0, "R7 alt wide A+A");

      // walking ripple across every boundary (R8)
      for (int k = 1; k < 16; k++)
         run16(16'((32'd1 << k) - 1), 16'd1, 1'b0, "R8 ripple");
      for (int k = 1; k < 64; k++)
         run64((64'd1 << k) - 64'd1, 64'd1, 1'b0, "R8 ripple wide");

      // signed reading: -1 + 1, most-negative + -1 (R1)
      run16(16'hFFFF, 16'h0001, 1'b0, "R1 signed -1+1");
      run16(16'h8000, 16'hFFFF, 1'b0, "R1 signed min-1");

      // random operands on default and wide builds (R1, R2, R9 builds)
      for (int i = 0; i < 1500; i++)
         run16(16'($urandom), 16'($urandom), 1'($urandom), "R1 R2 random");
      for (int i = 0; i < 500; i++)
         run64({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R9 R1 random wide");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule